// File: doc/BRIEF.md
# PC-Relative Literal Load Unit

This unit executes one class of instruction: a load whose address is the instruction's own location plus a signed word offset carried in the instruction. An upstream stage presents a 32-bit instruction word together with its 64-bit address and the current exception level. The unit recognises the encoding and forms the target address. It then issues one memory request over a valid/ready channel.

For the three load variants, the unit waits for read data on a valid/ready response channel. It resizes and extends the data to 64 bits and writes the result to the named register for one cycle. For the prefetch variant, it sends a hint request and finishes without waiting for data and without a register write. An instruction word that does not belong to this class is answered with a single-cycle "not handled" pulse.

The unit takes one instruction at a time. A new instruction is accepted only once the previous one has fully completed.

Top module: `litload_unit`

## Requirements
- R1: An instruction word is handled only when its bits 29 down to 24 equal 6'b011000. Any other word causes `nohandle` to be high for exactly the next cycle, with no memory request and no register write.
- R2: `req_addr` equals `in_pc` plus the offset, modulo 2^64. The offset is instruction bits 23..5, shifted left by two and sign-extended to 64 bits.
- R3: The variant is selected by the two-bit field formed from instruction bits {31,30}. `req_size8` is 1 (8 bytes) when bit 30 is 1, and 0 (4 bytes) when bit 30 is 0.
- R4: With field 2'b00, the register write carries read-data bits 31..0 in its low half and zeros in bits 63..32.
- R5: With field 2'b01, the register write carries all 64 read-data bits unchanged.
- R6: With field 2'b10, the register write carries read-data bits 31..0 sign-extended from bit 31 to 64 bits.
- R7: With field 2'b11, the request has `req_prefetch`=1 and `req_hint` equal to instruction bits 4..0. The unit then never asserts `rsp_ready` or `wr_en`, and `in_ready` is high in the cycle after the request is accepted.
- R8: `req_priv` is 1 exactly when the `in_el` value captured with the instruction is non-zero.
- R9: While `req_valid` is high and `req_ready` is low, the request stays asserted and all request fields hold their values.
- R10: `in_ready` is low from the cycle after an instruction is accepted until the cycle after its completion. For loads, completion is the register-write cycle. For prefetches, it is the request handshake.
- R11: For each load, `wr_en` is high for exactly one cycle, the cycle after the response handshake, whatever the data value. In that cycle `wr_idx` equals instruction bits 4..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit can take an instruction |
| in_insn | input | 32 | Instruction word |
| in_pc | input | 64 | Address of the instruction |
| in_el | input | 2 | Current exception level |
| nohandle | output | 1 | One-cycle pulse for an unrecognised word |
| req_valid | output | 1 | Memory request pending |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 64 | Target byte address |
| req_size8 | output | 1 | 1 = 8-byte access, 0 = 4-byte access |
| req_prefetch | output | 1 | Request is a prefetch hint, not a read |
| req_hint | output | 5 | Prefetch operation code |
| req_priv | output | 1 | Request made at a privileged level |
| rsp_valid | input | 1 | Read data offered |
| rsp_ready | output | 1 | Unit is waiting for read data |
| rsp_data | input | 64 | Read data |
| wr_en | output | 1 | Register-file write strobe |
| wr_idx | output | 5 | Register number to write |
| wr_data | output | 64 | Value to write |

## Verification
The hardest situations to reach are the edges of the address arithmetic. These are the most negative offset, the largest positive offset, and a sum that wraps past the top of the 64-bit space. Reaching them requires immediates at their extreme encodings, paired with chosen instruction addresses. The vector table places those encodings next to each variant and uses read data with bit 31 set or cleared, so that zero- and sign-extension give different results.

Every second vector also holds `req_ready` low for several cycles. This exercises request stability and the blocking of new instructions while the memory side stalls.

// File: rtl/litld_pkg.sv
package litld_pkg;

    localparam int XLEN  = 64;
    localparam int IW    = 32;
    localparam int IMMW  = 19;
    localparam int REGW  = 5;
    localparam int ELW   = 2;

    typedef enum logic [1:0] {
        KIND_LD32 = 2'b00,
        KIND_LD64 = 2'b01,
        KIND_LDSW = 2'b10,
        KIND_PREF = 2'b11
    } kind_e;

    typedef struct packed {
        logic            match;
        kind_e           kind;
        logic [IMMW-1:0] imm;
        logic [REGW-1:0] rt;
    } dec_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_RSP,
        ST_WB
    } state_e;

endpackage

// File: rtl/litld_decode.sv
module litld_decode
    import litld_pkg::*;
(
    input  logic [IW-1:0] insn,
    output dec_t          dec
);
    localparam logic [5:0] CLASS_BITS = 6'b011000;

    always_comb begin
        dec.match = (insn[29:24] == CLASS_BITS);
        dec.kind  = kind_e'({insn[31], insn[30]});
        dec.imm   = insn[23:5];
        dec.rt    = insn[4:0];
    end
endmodule

// File: rtl/litld_agen.sv
module litld_agen #(
    parameter int AW    = 64,
    parameter int IMMW  = 19,
    parameter int SCALE = 2
) (
    input  logic [AW-1:0]   base,
    input  logic [IMMW-1:0] imm,
    output logic [AW-1:0]   addr
);
    localparam int OFFW = IMMW + SCALE;
    localparam int EXTW = AW - OFFW;

    logic [OFFW-1:0] off_short;
    logic [AW-1:0]   off_full;

    always_comb begin
        off_short = {imm, {SCALE{1'b0}}};
        off_full  = {{EXTW{imm[IMMW-1]}}, off_short};
        addr      = base + off_full;
    end
endmodule

// File: rtl/litld_extend.sv
module litld_extend
    import litld_pkg::*;
#(
    parameter int DW = 64
) (
    input  kind_e         kind,
    input  logic [DW-1:0] raw,
    output logic [DW-1:0] value
);
    localparam int HW = DW / 2;

    logic [HW-1:0] low;

    always_comb begin
        low = raw[HW-1:0];
        case (kind)
            KIND_LD64: value = raw;
            KIND_LDSW: value = {{HW{low[HW-1]}}, low};
            default:   value = {{HW{1'b0}}, low};
        endcase
    end
endmodule

// File: rtl/litload_unit.sv
module litload_unit
    import litld_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [IW-1:0]    in_insn,
    input  logic [XLEN-1:0]  in_pc,
    input  logic [ELW-1:0]   in_el,
    output logic             nohandle,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [XLEN-1:0]  req_addr,
    output logic             req_size8,
    output logic             req_prefetch,
    output logic [REGW-1:0]  req_hint,
    output logic             req_priv,
    input  logic             rsp_valid,
    output logic             rsp_ready,
    input  logic [XLEN-1:0]  rsp_data,
    output logic             wr_en,
    output logic [REGW-1:0]  wr_idx,
    output logic [XLEN-1:0]  wr_data
);

    typedef struct packed {
        state_e          state;
        logic [XLEN-1:0] addr;
        kind_e           kind;
        logic [REGW-1:0] rt;
        logic            priv;
        logic            nohandle;
        logic            wr_en;
        logic [XLEN-1:0] wr_data;
    } ctx_t;

    localparam ctx_t CTX_RESET = '{
        state:    ST_IDLE,
        addr:     '0,
        kind:     KIND_LD32,
        rt:       '0,
        priv:     1'b0,
        nohandle: 1'b0,
        wr_en:    1'b0,
        wr_data:  '0
    };

    dec_t            dec;
    logic [XLEN-1:0] tgt_addr;
    logic [XLEN-1:0] ext_data;
    ctx_t            ctx_d, ctx_q;

    litld_decode u_decode (
        .insn (in_insn),
        .dec  (dec)
    );

    litld_agen #(
        .AW    (XLEN),
        .IMMW  (IMMW),
        .SCALE (2)
    ) u_agen (
        .base (in_pc),
        .imm  (dec.imm),
        .addr (tgt_addr)
    );

    litld_extend #(
        .DW (XLEN)
    ) u_extend (
        .kind  (ctx_q.kind),
        .raw   (rsp_data),
        .value (ext_data)
    );

    always_comb begin
        ctx_d          = ctx_q;
        ctx_d.nohandle = 1'b0;
        ctx_d.wr_en    = 1'b0;
        case (ctx_q.state)
            ST_IDLE: begin
                if (in_valid) begin
                    if (dec.match) begin
                        ctx_d.state = ST_REQ;
                        ctx_d.addr  = tgt_addr;
                        ctx_d.kind  = dec.kind;
                        ctx_d.rt    = dec.rt;
                        ctx_d.priv  = (in_el != '0);
                    end else begin
                        ctx_d.nohandle = 1'b1;
                    end
                end
            end
            ST_REQ: begin
                if (req_ready) begin
                    ctx_d.state = (ctx_q.kind == KIND_PREF) ? ST_IDLE : ST_RSP;
                end
            end
            ST_RSP: begin
                if (rsp_valid) begin
                    ctx_d.state   = ST_WB;
                    ctx_d.wr_en   = 1'b1;
                    ctx_d.wr_data = ext_data;
                end
            end
            default: begin
                ctx_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctx_q <= CTX_RESET;
        else        ctx_q <= ctx_d;
    end

    always_comb begin
        in_ready     = (ctx_q.state == ST_IDLE);
        req_valid    = (ctx_q.state == ST_REQ);
        rsp_ready    = (ctx_q.state == ST_RSP);
        req_addr     = ctx_q.addr;
        req_size8    = ctx_q.kind[0];
        req_prefetch = (ctx_q.kind == KIND_PREF);
        req_hint     = ctx_q.rt;
        req_priv     = ctx_q.priv;
        nohandle     = ctx_q.nohandle;
        wr_en        = ctx_q.wr_en;
        wr_idx       = ctx_q.rt;
        wr_data      = ctx_q.wr_data;
    end

    // R1: the "not handled" pulse is single-cycle and never comes with a request
    a_r1_nohandle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        nohandle |=> !nohandle);
    a_r1_nohandle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        nohandle |-> (!req_valid && !wr_en));

    // R9: a stalled request holds every field
    a_r9_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
            && $stable(req_size8) && $stable(req_prefetch)
            && $stable(req_hint) && $stable(req_priv)));

    // R7: a prefetch frees the unit right after its handshake
    a_r7_prefetch_release: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_prefetch) |=> (in_ready && !wr_en));

    // R11: write follows the response handshake by one cycle, and lasts one
    a_r11_wb_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> wr_en);
    a_r11_wb_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R10: no new instruction is taken during the write cycle
    a_r10_busy_on_wb: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !in_ready);

endmodule

// File: tb/litload_unit_bench.sv
module litload_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_insn = '0;
    logic [63:0] in_pc = '0;
    logic [1:0]  in_el = '0;
    logic        nohandle;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [63:0] req_addr;
    logic        req_size8;
    logic        req_prefetch;
    logic [4:0]  req_hint;
    logic        req_priv;
    logic        rsp_valid = 1'b0;
    logic        rsp_ready;
    logic [63:0] rsp_data = '0;
    logic        wr_en;
    logic [4:0]  wr_idx;
    logic [63:0] wr_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    litload_unit u_litload_unit (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready), .in_insn (in_insn),
        .in_pc (in_pc), .in_el (in_el), .nohandle (nohandle),
        .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
        .req_size8 (req_size8), .req_prefetch (req_prefetch),
        .req_hint (req_hint), .req_priv (req_priv),
        .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_data (rsp_data),
        .wr_en (wr_en), .wr_idx (wr_idx), .wr_data (wr_data)
    );

    typedef struct packed {
        logic [31:0] insn;
        logic [63:0] pc;
        logic [1:0]  el;
        logic [63:0] rdata;
        logic        handled;
        logic [63:0] addr;
        logic [63:0] wdata;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h18000023, 64'h1000,                64'h0 + 2'd0, 64'hFFFFFFFF80000001, 1'b1, 64'h1004,               64'h0000000080000001},
        '{32'h58FFFFE7, 64'h2000,                64'h0 + 2'd1, 64'h1122334455667788, 1'b1, 64'h1FFC,               64'h1122334455667788},
        '{32'h9800005F, 64'h100,                 64'h0 + 2'd2, 64'h0000000080000000, 1'b1, 64'h108,                64'hFFFFFFFF80000000},
        '{32'h98000000, 64'h40,                  64'h0 + 2'd0, 64'hAAAAAAAA7FFFFFFF, 1'b1, 64'h40,                 64'h000000007FFFFFFF},
        '{32'hD8800011, 64'h200000,              64'h0 + 2'd3, 64'h0,                1'b1, 64'h100000,             64'h0},
        '{32'h587FFFE1, 64'h0,                   64'h0 + 2'd0, 64'h8000000000000001, 1'b1, 64'hFFFFC,              64'h8000000000000001},
        '{32'h1C000000, 64'h3000,                64'h0 + 2'd1, 64'h0,                1'b0, 64'h0,                  64'h0},
        '{32'h18000029, 64'hFFFFFFFFFFFFFFFC,    64'h0 + 2'd1, 64'h00000000FFFFFFFF, 1'b1, 64'h0,                  64'h00000000FFFFFFFF},
        '{32'hF9400000, 64'h3000,                64'h0 + 2'd0, 64'h0,                1'b0, 64'h0,                  64'h0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input int i, input int stall);
        vec_t v;
        logic [1:0] fld;
        v = VECS[i];
        fld = v.insn[31:30];
        @(negedge clk);
        in_valid = 1'b1; in_insn = v.insn; in_pc = v.pc; in_el = v.el;
        @(negedge clk);
        in_valid = 1'b0;
        if (!v.handled) begin
            chk("R1 nohandle pulse", {63'h0, nohandle}, 64'h1);
            chk("R1 no request", {63'h0, req_valid}, 64'h0);
            @(negedge clk);
            chk("R1 pulse ends", {63'h0, nohandle}, 64'h0);
            chk("R1 no write", {63'h0, wr_en}, 64'h0);
            chk("R1 ready again", {63'h0, in_ready}, 64'h1);
            return;
        end
        chk("R1 no pulse on match", {63'h0, nohandle}, 64'h0);
        chk("R2 address", req_addr, v.addr);
        chk("R3 size", {63'h0, req_size8}, {63'h0, fld[0]});
        chk("R7 prefetch flag", {63'h0, req_prefetch}, {63'h0, fld == 2'b11});
        chk("R8 privilege", {63'h0, req_priv}, {63'h0, v.el != 2'd0});
        chk("R10 busy", {63'h0, in_ready}, 64'h0);
        if (fld == 2'b11) chk("R7 hint", {59'h0, req_hint}, {59'h0, v.insn[4:0]});
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk("R9 held valid", {63'h0, req_valid}, 64'h1);
            chk("R9 held addr", req_addr, v.addr);
            chk("R10 busy in stall", {63'h0, in_ready}, 64'h0);
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        if (fld == 2'b11) begin
            chk("R7 ready after prefetch", {63'h0, in_ready}, 64'h1);
            chk("R7 no rsp wait", {63'h0, rsp_ready}, 64'h0);
            @(negedge clk);
            chk("R7 no write", {63'h0, wr_en}, 64'h0);
            return;
        end
        chk("R10 waiting rsp", {62'h0, rsp_ready, in_ready}, 64'h2);
        @(negedge clk);
        chk("R11 no early write", {63'h0, wr_en}, 64'h0);
        rsp_valid = 1'b1; rsp_data = v.rdata;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_data = '0;
        chk("R11 write strobe", {63'h0, wr_en}, 64'h1);
        chk("R11 write index", {59'h0, wr_idx}, {59'h0, v.insn[4:0]});
        case (fld)
            2'b00:   chk("R4 zero-extended data", wr_data, v.wdata);
            2'b01:   chk("R5 full data", wr_data, v.wdata);
            default: chk("R6 sign-extended data", wr_data, v.wdata);
        endcase
        chk("R10 busy in write cycle", {63'h0, in_ready}, 64'h0);
        @(negedge clk);
        chk("R11 single write", {63'h0, wr_en}, 64'h0);
        chk("R10 ready after write", {63'h0, in_ready}, 64'h1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset ready", {63'h0, in_ready}, 64'h1);
        chk("R1 reset no pulse", {63'h0, nohandle}, 64'h0);
        chk("R9 reset no request", {63'h0, req_valid}, 64'h0);
        chk("R11 reset no write", {63'h0, wr_en}, 64'h0);
        for (int i = 0; i < NV; i++) run_vec(i, (i % 2) * 3);
        // R11 latency independent of data: same load with contrasting data
        for (int i = 0; i < 2; i++) run_vec(i == 0 ? 2 : 3, 0);
        // R1 idle input with garbage word but in_valid low: nothing happens
        @(negedge clk);
        in_insn = 32'h1C000000;
        @(negedge clk);
        chk("R1 idle ignored", {62'h0, nohandle, req_valid}, 64'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule